// File: doc/BRIEF.md
# Row Charge-Age Timer Table

This block sits beside the command scheduler of a DRAM memory controller and remembers, for a small number of recently closed rows, how long ago each row's cells were last brought back to charge. It watches three events. A precharge to a row creates or refreshes an entry. A periodic one-millisecond pulse ages every entry. An activate or write asks for the row's timing class. The class tells the scheduler whether it may use the fastest reduced activation, restore and write-recovery times, an intermediate reduced set, or the standard defaults.

Each entry stores a row tag, a saturating age counter and a flag that marks a row left only partly restored. The table is set-associative: the low row-address bits pick the set and the rest form the tag. A row that was left partly restored cannot simply be forgotten. When such an entry is pushed out of a full set, the block raises a one-cycle request that names the row. The scheduler then opens and closes that row so that its charge is fully restored.

Top module: `rct_timer_table`

## Requirements
- R1: After synchronous reset every entry is invalid, `cls_valid` and `restore_req` are low, and every lookup returns the default class.
- R2: A lookup request produces `cls_valid` high exactly one cycle later, with `cls_code` = 2'b10 when the entry's timer is 15, 2'b01 when the timer is between 1 and 14, and 2'b00 on a miss or when the timer is 0. `cls_valid` is low in every cycle that follows a cycle without a lookup. The code 2'b11 never appears.
- R3: A precharge to a row already in the table re-initialises that entry in place: the timer goes to 15 and the partial flag takes the `pre_partial` value. No second copy is made.
- R4: Each cycle with `tick_ms` high lowers every valid timer by one, and the timer stops at 0.
- R5: A precharge to a row not in the table fills the lowest-numbered invalid way of its set. Set = `row[SET_W-1:0]` and tag = the remaining upper bits. The new entry's timer is 15.
- R6: When the set is full, the victim is chosen by a tree pseudo-LRU. Node 0 is the root, and the children of node n are 2n+1 and 2n+2. A node bit of 0 steers the victim search left and 1 steers it right, with the way index built most-significant bit first. Every precharge that lands in a way sets the nodes on its path to point away from that way. Lookups do not change the pseudo-LRU state or any timer.
- R7: Evicting an entry whose partial flag is set raises `restore_req` for one cycle, one cycle after the precharge, with `restore_row` = {victim tag, set}. Evicting an entry whose flag is clear raises nothing.
- R8: Within one cycle, the tick is applied first, then the precharge, then the lookup. A lookup of the row being precharged in the same cycle therefore returns 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond; ages all entries |
| pre_valid | input | 1 | A precharge command is issued this cycle |
| pre_row | input | ROW_W | Row address of the precharge |
| pre_partial | input | 1 | The precharged row was left only partly restored |
| lkp_valid | input | 1 | An activate or write needs a timing class |
| lkp_row | input | ROW_W | Row address of the lookup |
| cls_valid | output | 1 | Registered: a class result is present |
| cls_code | output | 2 | Registered class: 00 default, 01 intermediate, 10 fastest |
| restore_req | output | 1 | Registered one-cycle request to open and close a row |
| restore_row | output | ROW_W | Row to be fully restored |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU victim is still flagged as partly restored. Reaching it takes eight distinct precharges into one set, followed by more precharges whose victim order depends on the whole history of the tree. The bench keeps an arithmetic model of the tree and the ages. It fills a set with flagged rows and then overflows it. It also overflows a set of unflagged rows to confirm that no restore is requested. A long pseudo-random phase on a narrow row range then keeps sets full while ticks, precharges and same-row lookups land in the same cycles.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef enum logic [1:0] {
    CLS_DEFAULT = 2'b00,
    CLS_MID     = 2'b01,
    CLS_FAST    = 2'b10
  } cls_e;

endpackage

// File: rtl/rct_way_match.sv
module rct_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o
);

  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) idx_o = IDX_W'(w);
    end
  end

endmodule

// File: rtl/rct_plru.sv
module rct_plru #(
  parameter int WAYS  = 8,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  bits_i,
  input  logic [IDX_W-1:0] touch_i,
  output logic [IDX_W-1:0] victim_o,
  output logic [WAYS-2:0]  bits_o
);

  localparam int NW = IDX_W + 1;

  logic [NW-1:0] vnode;
  logic [NW-1:0] tnode;
  logic          vb;
  logic          td;

  always_comb begin
    vnode    = '0;
    victim_o = '0;
    vb       = 1'b0;
    for (int l = 0; l < IDX_W; l++) begin
      vb       = bits_i[vnode[IDX_W-1:0]];
      victim_o = (victim_o << 1) | IDX_W'(vb);
      vnode    = (vnode << 1) + NW'(1) + NW'(vb);
    end
  end

  always_comb begin
    bits_o = bits_i;
    tnode  = '0;
    td     = 1'b0;
    for (int l = 0; l < IDX_W; l++) begin
      td = touch_i[IDX_W-1-l];
      bits_o[tnode[IDX_W-1:0]] = ~td;
      tnode = (tnode << 1) + NW'(1) + NW'(td);
    end
  end

endmodule

// File: rtl/rct_class_map.sv
module rct_class_map
  import rct_pkg::*;
#(
  parameter int TIMER_W = 4
) (
  input  logic               hit_i,
  input  logic [TIMER_W-1:0] timer_i,
  output cls_e               cls_o
);

  localparam logic [TIMER_W-1:0] TMAX = '1;

  always_comb begin
    if (!hit_i || timer_i == '0) cls_o = CLS_DEFAULT;
    else if (timer_i == TMAX)    cls_o = CLS_FAST;
    else                         cls_o = CLS_MID;
  end

endmodule

// File: rtl/rct_timer_table.sv
module rct_timer_table
  import rct_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int SETS    = 4,
  parameter int WAYS    = 8,
  parameter int TIMER_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             pre_valid,
  input  logic [ROW_W-1:0] pre_row,
  input  logic             pre_partial,
  input  logic             lkp_valid,
  input  logic [ROW_W-1:0] lkp_row,
  output logic             cls_valid,
  output logic [1:0]       cls_code,
  output logic             restore_req,
  output logic [ROW_W-1:0] restore_row
);

  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ROW_W - SET_W;
  localparam int IDX_W = $clog2(WAYS);
  localparam logic [TIMER_W-1:0] TMAX = '1;

  logic [WAYS-1:0]              vld_q [SETS];
  logic [WAYS-1:0]              pr_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q [SETS];
  logic [WAYS-1:0][TIMER_W-1:0] tmr_q [SETS];
  logic [WAYS-2:0]              plru_q[SETS];

  logic [WAYS-1:0]              vld_d [SETS];
  logic [WAYS-1:0]              pr_d  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_d [SETS];
  logic [WAYS-1:0][TIMER_W-1:0] tmr_d [SETS];
  logic [WAYS-2:0]              plru_d[SETS];

  // precharge side
  logic [SET_W-1:0] pre_set;
  logic [TAG_W-1:0] pre_tag;
  logic             pre_hit;
  logic [IDX_W-1:0] pre_hit_idx;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] victim;
  logic [IDX_W-1:0] alloc_way;
  logic [WAYS-2:0]  plru_new;
  logic             evict;
  logic [ROW_W-1:0] evict_row;

  assign pre_set = pre_row[SET_W-1:0];
  assign pre_tag = pre_row[ROW_W-1:SET_W];

  rct_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pre_match (
    .valid_i (vld_q[pre_set]),
    .tag_i   (tag_q[pre_set]),
    .key_i   (pre_tag),
    .hit_o   (pre_hit),
    .idx_o   (pre_hit_idx)
  );

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[pre_set][w]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(w);
      end
    end
  end

  rct_plru #(.WAYS(WAYS)) u_plru (
    .bits_i   (plru_q[pre_set]),
    .touch_i  (alloc_way),
    .victim_o (victim),
    .bits_o   (plru_new)
  );

  always_comb begin
    if (pre_hit)       alloc_way = pre_hit_idx;
    else if (free_any) alloc_way = free_idx;
    else               alloc_way = victim;
  end

  assign evict     = pre_valid && !pre_hit && !free_any && pr_q[pre_set][victim];
  assign evict_row = {tag_q[pre_set][victim], pre_set};

  // next state: age, then insert
  always_comb begin
    vld_d  = vld_q;
    pr_d   = pr_q;
    tag_d  = tag_q;
    tmr_d  = tmr_q;
    plru_d = plru_q;
    if (tick_ms) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (vld_q[s][w] && tmr_q[s][w] != '0)
            tmr_d[s][w] = tmr_q[s][w] - TIMER_W'(1);
        end
      end
    end
    if (pre_valid) begin
      vld_d[pre_set][alloc_way] = 1'b1;
      pr_d[pre_set][alloc_way]  = pre_partial;
      tag_d[pre_set][alloc_way] = pre_tag;
      tmr_d[pre_set][alloc_way] = TMAX;
      plru_d[pre_set]           = plru_new;
    end
  end

  // lookup side sees the post-update table
  logic [SET_W-1:0]   lkp_set;
  logic [TAG_W-1:0]   lkp_tag;
  logic               lkp_hit;
  logic [IDX_W-1:0]   lkp_idx;
  logic [TIMER_W-1:0] lkp_tmr;
  cls_e               lkp_cls;

  assign lkp_set = lkp_row[SET_W-1:0];
  assign lkp_tag = lkp_row[ROW_W-1:SET_W];

  rct_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lkp_match (
    .valid_i (vld_d[lkp_set]),
    .tag_i   (tag_d[lkp_set]),
    .key_i   (lkp_tag),
    .hit_o   (lkp_hit),
    .idx_o   (lkp_idx)
  );

  assign lkp_tmr = tmr_d[lkp_set][lkp_idx];

  rct_class_map #(.TIMER_W(TIMER_W)) u_class (
    .hit_i   (lkp_hit),
    .timer_i (lkp_tmr),
    .cls_o   (lkp_cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        pr_q[s]   <= '0;
        tag_q[s]  <= '0;
        tmr_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      cls_valid   <= 1'b0;
      cls_code    <= CLS_DEFAULT;
      restore_req <= 1'b0;
      restore_row <= '0;
    end else begin
      vld_q       <= vld_d;
      pr_q        <= pr_d;
      tag_q       <= tag_d;
      tmr_q       <= tmr_d;
      plru_q      <= plru_d;
      cls_valid   <= lkp_valid;
      cls_code    <= lkp_valid ? lkp_cls : CLS_DEFAULT;
      restore_req <= evict;
      if (evict) restore_row <= evict_row;
    end
  end

endmodule

// File: rtl/rct_timer_table_chk.sv
module rct_timer_table_chk #(
  parameter int ROW_W = 14,
  parameter int SETS  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pre_valid,
  input logic [ROW_W-1:0] pre_row,
  input logic             lkp_valid,
  input logic [ROW_W-1:0] lkp_row,
  input logic             cls_valid,
  input logic [1:0]       cls_code,
  input logic             restore_req,
  input logic [ROW_W-1:0] restore_row
);

  localparam int SET_W = $clog2(SETS);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!cls_valid && !restore_req)); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cls_code != 2'b11); // R2

  AST_CLS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> cls_valid); // R2

  AST_CLS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !cls_valid); // R2

  AST_RESTORE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> $past(pre_valid)); // R7

  AST_RESTORE_SET: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (restore_row[SET_W-1:0] == $past(pre_row[SET_W-1:0])
                     && restore_row != $past(pre_row))); // R7

  AST_SAME_ROW_FAST: assert property (@(posedge clk) disable iff (rst)
    (pre_valid && lkp_valid && pre_row == lkp_row) |=> cls_code == 2'b10); // R8

endmodule

bind rct_timer_table rct_timer_table_chk #(.ROW_W(ROW_W), .SETS(SETS)) chk_i (
  .clk(clk), .rst(rst), .pre_valid(pre_valid), .pre_row(pre_row),
  .lkp_valid(lkp_valid), .lkp_row(lkp_row), .cls_valid(cls_valid),
  .cls_code(cls_code), .restore_req(restore_req), .restore_row(restore_row)
);

// File: tb/rct_timer_table_tb_top.sv
module rct_timer_table_tb_top;

  localparam int ROW_W = 6;
  localparam int SETS  = 2;
  localparam int WAYS  = 8;
  localparam int LVL   = 3;
  localparam int TMAXV = 15;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_ms = 1'b0;
  logic             pre_valid = 1'b0;
  logic [ROW_W-1:0] pre_row = '0;
  logic             pre_partial = 1'b0;
  logic             lkp_valid = 1'b0;
  logic [ROW_W-1:0] lkp_row = '0;
  logic             cls_valid;
  logic [1:0]       cls_code;
  logic             restore_req;
  logic [ROW_W-1:0] restore_row;

  always #5 clk = ~clk;

  rct_timer_table #(.ROW_W(ROW_W), .SETS(SETS), .WAYS(WAYS), .TIMER_W(4)) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .pre_valid(pre_valid),
    .pre_row(pre_row), .pre_partial(pre_partial), .lkp_valid(lkp_valid),
    .lkp_row(lkp_row), .cls_valid(cls_valid), .cls_code(cls_code),
    .restore_req(restore_req), .restore_row(restore_row)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model
  bit m_vld [SETS][WAYS];
  bit m_pr  [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_tmr [SETS][WAYS];
  bit m_plru[SETS][WAYS-1];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_pr[s][w] = 0; m_tag[s][w] = 0; m_tmr[s][w] = 0;
        if (w < WAYS - 1) m_plru[s][w] = 0;
      end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(input bit pv, input int prow, input bit pp,
                      input bit lv, input int lrow, input bit tk);
    bit exp_rr;
    int exp_row, exp_code;
    int s, t, hw, fw, vw, node, b;
    exp_rr = 0; exp_row = 0; exp_code = 0;
    if (tk)
      for (int i = 0; i < SETS; i++)
        for (int w = 0; w < WAYS; w++)
          if (m_vld[i][w] && m_tmr[i][w] > 0) m_tmr[i][w]--;
    if (pv) begin
      s = prow % SETS; t = prow / SETS; hw = -1; fw = -1;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
        if (!m_vld[s][w]) fw = w;
      end
      if (hw < 0 && fw >= 0) hw = fw;
      if (hw < 0) begin
        node = 0; vw = 0;
        for (int l = 0; l < LVL; l++) begin
          b = m_plru[s][node]; vw = vw * 2 + b; node = 2 * node + 1 + b;
        end
        if (m_pr[s][vw]) begin exp_rr = 1; exp_row = m_tag[s][vw] * SETS + s; end
        hw = vw;
      end
      m_vld[s][hw] = 1; m_pr[s][hw] = pp; m_tag[s][hw] = t; m_tmr[s][hw] = TMAXV;
      node = 0;
      for (int l = LVL - 1; l >= 0; l--) begin
        b = (hw >> l) & 1; m_plru[s][node] = !b; node = 2 * node + 1 + b;
      end
    end
    if (lv) begin
      s = lrow % SETS; t = lrow / SETS; exp_code = 0;
      for (int w = 0; w < WAYS; w++)
        if (m_vld[s][w] && m_tag[s][w] == t)
          exp_code = (m_tmr[s][w] == TMAXV) ? 2 : (m_tmr[s][w] == 0 ? 0 : 1);
    end
    pre_valid = pv; pre_row = ROW_W'(prow); pre_partial = pp;
    lkp_valid = lv; lkp_row = ROW_W'(lrow); tick_ms = tk;
    @(posedge clk);
    #1;
    pre_valid = 0; lkp_valid = 0; tick_ms = 0; pre_partial = 0;
    chk(cls_valid == lv, "cls_valid", int'(cls_valid), int'(lv));
    if (lv) chk(cls_code == 2'(exp_code), "cls_code", int'(cls_code), exp_code);
    chk(restore_req == exp_rr, "restore_req", int'(restore_req), int'(exp_rr));
    if (exp_rr) chk(restore_row == ROW_W'(exp_row), "restore_row", int'(restore_row), exp_row);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    // R1: reset state and misses
    do_reset();
    cur_req = "R1";
    chk(!cls_valid && !restore_req, "reset outputs", int'(cls_valid), 0);
    for (int r = 0; r < 4; r++) step(0, 0, 0, 1, r, 0);

    // R4 / R2: age sweep, expected class computed arithmetically
    cur_req = "R4";
    for (int k = 0; k <= 17; k++) begin
      int tv, ec;
      do_reset();
      step(1, 5, 0, 0, 0, 0);
      for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 1);
      tv = (k >= TMAXV) ? 0 : TMAXV - k;
      ec = (tv == TMAXV) ? 2 : (tv == 0 ? 0 : 1);
      cur_req = "R2";
      step(0, 0, 0, 1, 5, 0);
      chk(cls_code == 2'(ec), "arith class", int'(cls_code), ec);
      cur_req = "R4";
    end

    // R3: re-initialise existing row, no duplicate
    cur_req = "R3";
    do_reset();
    step(1, 9, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1);
    step(1, 9, 0, 1, 9, 0);
    for (int r = 1; r < 8; r++) step(1, 1 + 2 * r + 8, 1, 0, 0, 0);
    step(1, 63, 1, 1, 9, 0);

    // R5 / R6 / R7: fill set 0 with flagged rows, then overflow
    cur_req = "R5";
    do_reset();
    for (int r = 0; r < WAYS; r++) step(1, 2 * r, 1, 1, 2 * r, 0);
    cur_req = "R6";
    for (int r = 0; r < 12; r++) step(1, 40 + 2 * r, r % 3 != 0, 0, 0, 0);
    step(1, 4, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    cur_req = "R7";
    for (int r = 0; r < 10; r++) step(1, 20 + 2 * r, 0, 0, 0, 0);

    // R8: dense pseudo-random mix with same-cycle collisions
    cur_req = "R8";
    do_reset();
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      bit pv, pp, lv, tk;
      int pr, lr;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pv = lf[0] | lf[1];
      pp = lf[2];
      lv = lf[3] | lf[4];
      tk = (lf[7:5] == 3'd0);
      pr = int'(lf[12:8]) % 24;
      lr = lf[13] ? pr : int'(lf[15:11]) % 24;
      step(pv, pr, pp, lv, lr, tk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule